// File: doc/BRIEF.md
# Conjugate Reference Spectrum Multiplier

This block takes one line of complex frequency-domain samples at a time and multiplies each sample by the complex conjugate of a stored reference spectrum, bin by bin. The result is the frequency-domain step of a matched filter. An inverse transform after this block turns the result into the correlation output. The products are rounded to the output width and clamped symmetrically. A sticky flag records any clamp.

The reference line is held in an on-chip memory that is written through a simple load port. Two operating modes exist. In range mode a single loaded reference serves every line that follows. In azimuth mode each line needs its own reference, so the block stops accepting samples after the last bin of a line. It accepts samples again only when a new reference has been written. Samples can also arrive in a packed raw format, with a small signed real field and a small signed imaginary field, each zero-padded to one byte. The block sign-extends those fields before the multiply.

Top module: `mf_conj_mult`

## Requirements
- R1: For each accepted sample a at bin k, with reference b = ref[k], the output real part is ar·br + ai·bi and the imaginary part is ai·br − ar·bi. Both are formed at full precision before rounding. Sample, reference and output words carry the real part in the low half and the imaginary part in the high half.
- R2: Each full-precision part is rounded by adding 2^(SHIFT−1) and shifting right arithmetically by SHIFT (SHIFT = 15 by default). It is then clamped to the range ±(2^(OW−1)−1). The value −2^(OW−1) never appears on the output.
- R3: `ovf_sticky` is 0 after reset. It becomes 1 in the cycle the first clamped product appears on the output, and it stays 1 until reset.
- R4: With the output not stalled, a sample accepted on one clock edge appears on the output with `out_valid` high after the third following register stage. This is 3 cycles of latency.
- R5: While `out_valid` is high and `out_ready` is low, the output word is held unchanged and `in_ready` is low. No sample is dropped or duplicated.
- R6: In range mode (`mode_az` = 0), the loaded reference is used for every later line, and `in_ready` stays high across line ends.
- R7: In azimuth mode (`mode_az` = 1), `in_ready` goes low after the sample at bin LINE_LEN−1 is accepted. It stays low until the reference entry at address LINE_LEN−1 is written. The next line then uses the newly written reference.
- R8: After reset, `in_ready` stays low until the reference entry at address LINE_LEN−1 has been written.
- R9: When `in_packed` = 1, the real part is `in_data[4:0]` and the imaginary part is `in_data[12:8]`. Both are 5-bit two's complement fields, and each is sign-extended to IW bits.
- R10: An accepted sample with `in_sol` high uses bin 0. Each following accepted sample uses the next bin, and the bin wraps from LINE_LEN−1 to 0.
- R11: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_az | input | 1 | 0: range mode (reference reused), 1: azimuth mode (reference reloaded per line) |
| in_packed | input | 1 | 1: input word is two zero-padded bytes with 5-bit signed fields |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sol | input | 1 | Marks the accepted sample as bin 0 of a new line |
| in_data | input | 2*IW | Input sample, real in low half, imaginary in high half |
| ref_we | input | 1 | Reference write strobe |
| ref_addr | input | clog2(LINE_LEN) | Reference bin address |
| ref_data | input | 2*RW | Reference value, real in low half, imaginary in high half |
| out_ready | input | 1 | Downstream can take an output |
| out_valid | output | 1 | Output product valid |
| out_data | output | 2*OW | Rounded product, real in low half, imaginary in high half |
| ovf_sticky | output | 1 | Set once any product has been clamped |

## Verification
The assertions check on every cycle that the negative full-scale code never leaves the block, that the overflow flag never falls, and that a stalled output holds its word. They also check that the three-stage latency holds when the path is not stalled, that the bin index stays inside the line, and that azimuth mode closes the input after the last bin unless a reload lands in the same cycle. Only the bench scenarios can show the arithmetic itself. These scenarios cover the conjugate product at each bin, the exact rounding and clamp values, and the reuse of one reference over several range-mode lines. They also cover the switch to a fresh reference after an azimuth reload, the decoding of packed bytes, and the reset of the bin index by a line-start strobe in the middle of a line.

// File: rtl/mf_pkg.sv
`timescale 1ns/1ps
package mf_pkg;
  typedef enum logic {
    MF_RANGE   = 1'b0,
    MF_AZIMUTH = 1'b1
  } mf_mode_e;

  // packed raw format: one signed field per byte, upper bits padding
  localparam int PACK_FW   = 5;
  localparam int PACK_BYTE = 8;
endpackage

// File: rtl/mf_unpack.sv
`timescale 1ns/1ps
module mf_unpack
  import mf_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic                 packed_fmt,
  input  logic [2*IW-1:0]      din,
  output logic signed [IW-1:0] re,
  output logic signed [IW-1:0] im
);
  logic [PACK_FW-1:0] f_re;
  logic [PACK_FW-1:0] f_im;

  assign f_re = din[PACK_FW-1:0];
  assign f_im = din[PACK_BYTE +: PACK_FW];

  always_comb begin
    if (packed_fmt) begin
      re = {{(IW-PACK_FW){f_re[PACK_FW-1]}}, f_re};
      im = {{(IW-PACK_FW){f_im[PACK_FW-1]}}, f_im};
    end else begin
      re = din[IW-1:0];
      im = din[2*IW-1:IW];
    end
  end
endmodule

// File: rtl/mf_ref_ram.sv
`timescale 1ns/1ps
module mf_ref_ram #(
  parameter int DEPTH = 4096,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mf_line_ctrl.sv
`timescale 1ns/1ps
module mf_line_ctrl
  import mf_pkg::*;
#(
  parameter int LINE_LEN = 4096,
  localparam int AW      = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  mf_mode_e      mode,
  input  logic          en,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          ref_we,
  input  logic [AW-1:0] ref_addr,
  output logic          in_ready,
  output logic          acc,
  output logic [AW-1:0] bin
);
  localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

  logic [AW-1:0] idx;
  logic          ref_ok;
  logic          load_last;
  logic          line_end;

  assign bin       = in_sol ? '0 : idx;
  assign in_ready  = en & ref_ok;
  assign acc       = in_valid & in_ready;
  assign load_last = ref_we && (ref_addr == LAST);
  assign line_end  = acc && (bin == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (acc) begin
      idx <= (bin == LAST) ? '0 : bin + 1'b1;
    end
  end

  // reference availability: a completed load opens the input,
  // azimuth mode closes it again at the end of each line
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_ok <= 1'b0;
    end else if (load_last) begin
      ref_ok <= 1'b1;
    end else if (line_end && mode == MF_AZIMUTH) begin
      ref_ok <= 1'b0;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST); // R10

  AST_AZ_GATE: assert property (@(posedge clk) disable iff (rst)
    (mode == MF_AZIMUTH && line_end && !load_last) |=> !in_ready); // R7

  AST_RANGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (mode == MF_RANGE && ref_ok) |=> ref_ok); // R6
endmodule

// File: rtl/mf_cmul.sv
`timescale 1ns/1ps
module mf_cmul #(
  parameter int IW    = 16,
  parameter int RW    = 16,
  parameter int OW    = 16,
  parameter int SHIFT = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 v_in,
  input  logic signed [IW-1:0] a_i,
  input  logic signed [IW-1:0] a_q,
  input  logic signed [RW-1:0] b_i,
  input  logic signed [RW-1:0] b_q,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q,
  output logic                 ovf
);
  localparam int PW   = IW + RW;
  localparam int SW   = PW + 1;
  localparam int MAXI = (1 << (OW - 1)) - 1;
  localparam logic signed [SW:0] MAXV = (SW+1)'(MAXI);
  localparam logic signed [SW:0] MINV = -MAXV;

  // stage 1: sample aligned with registered reference read
  logic                 s1_v;
  logic signed [IW-1:0] s1_ai, s1_aq;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else if (en) s1_v <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_ai <= a_i;
      s1_aq <= a_q;
    end
  end

  // stage 2: four partial products
  logic                 s2_v;
  logic signed [PW-1:0] p_rr, p_ii, p_ir, p_ri;

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else if (en) s2_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      p_rr <= s1_ai * b_i;
      p_ii <= s1_aq * b_q;
      p_ir <= s1_aq * b_i;
      p_ri <= s1_ai * b_q;
    end
  end

  // stage 3: conjugate sums, rounding, symmetric clamp
  logic signed [SW-1:0] re_sum, im_sum;
  logic signed [SW:0]   re_ext, im_ext;
  logic signed [SW:0]   re_rnd, im_rnd;
  logic signed [SW:0]   re_shf, im_shf;
  logic [OW:0]          re_s, im_s;

  assign re_sum = {p_rr[PW-1], p_rr} + {p_ii[PW-1], p_ii};
  assign im_sum = {p_ir[PW-1], p_ir} - {p_ri[PW-1], p_ri};
  assign re_ext = {re_sum[SW-1], re_sum};
  assign im_ext = {im_sum[SW-1], im_sum};

  generate
    if (SHIFT > 0) begin : g_round
      localparam logic signed [SW:0] RND = (SW+1)'(1) <<< (SHIFT - 1);
      assign re_rnd = re_ext + RND;
      assign im_rnd = im_ext + RND;
    end else begin : g_exact
      assign re_rnd = re_ext;
      assign im_rnd = im_ext;
    end
  endgenerate

  assign re_shf = re_rnd >>> SHIFT;
  assign im_shf = im_rnd >>> SHIFT;

  // returns {clamped, value}
  function automatic logic [OW:0] clamp_fn(input logic signed [SW:0] v);
    if (v > MAXV)      return {1'b1, MAXV[OW-1:0]};
    else if (v < MINV) return {1'b1, MINV[OW-1:0]};
    else               return {1'b0, v[OW-1:0]};
  endfunction

  assign re_s = clamp_fn(re_shf);
  assign im_s = clamp_fn(im_shf);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ovf       <= 1'b0;
    end else if (en) begin
      out_valid <= s2_v;
      ovf       <= ovf | (s2_v & (re_s[OW] | im_s[OW]));
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_i <= re_s[OW-1:0];
      out_q <= im_s[OW-1:0];
    end
  end

  AST_SYM_SAT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_i != {1'b1, {(OW-1){1'b0}}}) && (out_q != {1'b1, {(OW-1){1'b0}}})); // R2

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !en) |=> out_valid && $stable(out_i) && $stable(out_q)); // R5
endmodule

// File: rtl/mf_conj_mult.sv
`timescale 1ns/1ps
module mf_conj_mult
  import mf_pkg::*;
#(
  parameter int LINE_LEN = 4096,
  parameter int IW       = 16,
  parameter int RW       = 16,
  parameter int OW       = 16,
  parameter int SHIFT    = 15,
  localparam int AW      = $clog2(LINE_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_az,
  input  logic            in_packed,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_sol,
  input  logic [2*IW-1:0] in_data,
  input  logic            ref_we,
  input  logic [AW-1:0]   ref_addr,
  input  logic [2*RW-1:0] ref_data,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [2*OW-1:0] out_data,
  output logic            ovf_sticky
);
  mf_mode_e             mode;
  logic                 en;
  logic                 acc;
  logic [AW-1:0]        bin;
  logic signed [IW-1:0] a_i, a_q;
  logic [2*RW-1:0]      ref_rd;
  logic signed [RW-1:0] b_i, b_q;
  logic signed [OW-1:0] o_i, o_q;

  assign mode = mf_mode_e'(mode_az);
  // the whole pipeline advances only when the output slot can move
  assign en   = !out_valid || out_ready;

  mf_line_ctrl #(.LINE_LEN(LINE_LEN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .en       (en),
    .in_valid (in_valid),
    .in_sol   (in_sol),
    .ref_we   (ref_we),
    .ref_addr (ref_addr),
    .in_ready (in_ready),
    .acc      (acc),
    .bin      (bin)
  );

  mf_unpack #(.IW(IW)) u_unpack (
    .packed_fmt (in_packed),
    .din        (in_data),
    .re         (a_i),
    .im         (a_q)
  );

  mf_ref_ram #(.DEPTH(LINE_LEN), .DW(2*RW)) u_ram (
    .clk   (clk),
    .we    (ref_we),
    .waddr (ref_addr),
    .wdata (ref_data),
    .re    (acc),
    .raddr (bin),
    .rdata (ref_rd)
  );

  assign b_i = ref_rd[RW-1:0];
  assign b_q = ref_rd[2*RW-1:RW];

  mf_cmul #(.IW(IW), .RW(RW), .OW(OW), .SHIFT(SHIFT)) u_cmul (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .v_in      (acc),
    .a_i       (a_i),
    .a_q       (a_q),
    .b_i       (b_i),
    .b_q       (b_q),
    .out_valid (out_valid),
    .out_i     (o_i),
    .out_q     (o_q),
    .ovf       (ovf_sticky)
  );

  assign out_data = {o_q, o_i};

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ($past(acc, 2) && $past(en, 1) && en) |=> out_valid); // R4

  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R5
endmodule

// File: tb/mf_conj_mult_tb_top.sv
`timescale 1ns/1ps
module mf_conj_mult_tb_top;
  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;
  localparam int LEN    = 64;
  localparam int IW     = 16;
  localparam int RW     = 16;
  localparam int OW     = 16;
  localparam int SHIFT  = 15;
  localparam int AW     = $clog2(LEN);
  localparam int QD     = 4096;
  localparam int MAXO   = (1 << (OW - 1)) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mode_az = 1'b0;
  logic            in_packed = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_sol = 1'b0;
  logic [2*IW-1:0] in_data = '0;
  logic            ref_we = 1'b0;
  logic [AW-1:0]   ref_addr = '0;
  logic [2*RW-1:0] ref_data = '0;
  logic            out_ready = 1'b1;
  logic            in_ready, out_valid, ovf_sticky;
  logic [2*OW-1:0] out_data;

  always #(HALF) clk = ~clk;

  mf_conj_mult #(.LINE_LEN(LEN), .IW(IW), .RW(RW), .OW(OW), .SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst(rst), .mode_az(mode_az), .in_packed(in_packed),
    .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol), .in_data(in_data),
    .ref_we(ref_we), .ref_addr(ref_addr), .ref_data(ref_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .ovf_sticky(ovf_sticky)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    ref_i [LEN];
  int    ref_q [LEN];
  int    exp_i [QD];
  int    exp_q [QD];
  int    wp = 0;
  int    rp = 0;
  int    tb_idx = 0;
  bit    bp_en = 1'b0;
  bit    finished = 1'b0;
  string mon_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int round_clamp(input longint v);
    longint r;
    r = (v + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
    if (r > MAXO) return MAXO;
    if (r < -MAXO) return -MAXO;
    return int'(r);
  endfunction

  task automatic push_exp(input int bin, input int ai, input int aq);
    longint re, im;
    re = longint'(ai) * ref_i[bin] + longint'(aq) * ref_q[bin];
    im = longint'(aq) * ref_i[bin] - longint'(ai) * ref_q[bin];
    exp_i[wp % QD] = round_clamp(re);
    exp_q[wp % QD] = round_clamp(im);
    wp++;
  endtask

  function automatic int rnd_small();
    return int'($urandom_range(32766)) - 16383;
  endfunction

  function automatic int rnd_5b();
    return int'($urandom_range(31)) - 16;
  endfunction

  task automatic fill_ref_random();
    for (int k = 0; k < LEN; k++) begin
      ref_i[k] = rnd_small();
      ref_q[k] = rnd_small();
    end
  endtask

  task automatic load_ref(input int lo, input int hi);
    for (int k = lo; k <= hi; k++) begin
      @(negedge clk);
      ref_we   = 1'b1;
      ref_addr = AW'(k);
      ref_data = {ref_q[k][RW-1:0], ref_i[k][RW-1:0]};
    end
    @(negedge clk);
    ref_we = 1'b0;
  endtask

  task automatic send(input bit sol, input bit pk, input int ai, input int aq);
    bit got;
    int bin;
    got = 1'b0;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sol    = sol;
    in_packed = pk;
    if (pk) in_data = {16'h0000, 3'b000, aq[4:0], 3'b000, ai[4:0]};
    else    in_data = {aq[IW-1:0], ai[IW-1:0]};
    while (!got) begin
      #(HALF - 1);
      got = in_ready;
      @(posedge clk);
      if (!got) @(negedge clk);
    end
    #1;
    in_valid = 1'b0;
    in_sol   = 1'b0;
    bin = sol ? 0 : tb_idx;
    push_exp(bin, pk ? ai : ai, aq);
    tb_idx = (bin == LEN - 1) ? 0 : bin + 1;
  endtask

  task automatic send_line(input bit pk, input bit gaps);
    for (int k = 0; k < LEN; k++) begin
      if (gaps && ($urandom_range(4) == 0)) @(negedge clk);
      if (pk) send(k == 0, 1'b1, rnd_5b(), rnd_5b());
      else    send(k == 0, 1'b0, rnd_small(), rnd_small());
    end
  endtask

  task automatic drain();
    bp_en = 1'b0;
    while (rp != wp) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sample_ready(input string req, input bit expv);
    @(negedge clk);
    #(HALF - 1);
    chk(in_ready == expv, req, int'(in_ready), int'(expv));
  endtask

  // output monitor: random backpressure, compare in order, check holds
  initial begin
    bit            prev_stall;
    logic [2*OW-1:0] prev_data;
    int            ai, aq;
    prev_stall = 1'b0;
    prev_data  = '0;
    forever begin
      @(negedge clk);
      out_ready = bp_en ? ($urandom_range(3) != 0) : 1'b1;
      #(HALF - 1);
      if (!rst) begin
        if (prev_stall) begin
          chk(out_valid && out_data == prev_data, "R5", int'(out_data), int'(prev_data));
        end
        if (out_valid && !out_ready) begin
          chk(!in_ready, "R5", int'(in_ready), 0);
        end
        if (out_valid && out_ready) begin
          ai = int'($signed(out_data[OW-1:0]));
          aq = int'($signed(out_data[2*OW-1:OW]));
          if (rp == wp) begin
            chk(1'b0, mon_req, ai, 0);
          end else begin
            chk(ai == exp_i[rp % QD], {mon_req, " real"}, ai, exp_i[rp % QD]);
            chk(aq == exp_q[rp % QD], {mon_req, " imag"}, aq, exp_q[rp % QD]);
            rp++;
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11 / R8 / R3: reset state
    @(negedge clk);
    #(HALF - 1);
    chk(out_valid == 1'b0, "R11", int'(out_valid), 0);
    chk(ovf_sticky == 1'b0, "R3", int'(ovf_sticky), 0);
    chk(in_ready == 1'b0, "R8", int'(in_ready), 0);

    // R8: partial load keeps input closed, last entry opens it
    fill_ref_random();
    load_ref(0, LEN - 2);
    sample_ready("R8", 1'b0);
    load_ref(LEN - 1, LEN - 1);
    sample_ready("R8", 1'b1);

    // R4: single sample latency with no stall
    mon_req = "R4";
    send(1'b1, 1'b0, rnd_small(), rnd_small());
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      #(HALF - 1);
      chk(out_valid == (k == 3), "R4", int'(out_valid), int'(k == 3));
    end
    drain();

    // R1 / R6 / R5: range mode, several lines, random stalls and gaps
    mon_req = "R1";
    bp_en = 1'b1;
    send_line(1'b0, 1'b1);
    drain();
    sample_ready("R6", 1'b1);
    mon_req = "R6";
    bp_en = 1'b1;
    send_line(1'b0, 1'b1);
    send_line(1'b0, 1'b0);
    drain();
    sample_ready("R6", 1'b1);

    // R10: line start strobe mid line, then wrap without strobe
    mon_req = "R10";
    bp_en = 1'b1;
    for (int k = 0; k < 10; k++) send(k == 0, 1'b0, rnd_small(), rnd_small());
    send(1'b1, 1'b0, rnd_small(), rnd_small());
    for (int k = 0; k < LEN + 5; k++) send(1'b0, 1'b0, rnd_small(), rnd_small());
    drain();

    // R9: packed byte format including field extremes
    mon_req = "R9";
    send(1'b1, 1'b1, -16, 15);
    send(1'b0, 1'b1, 15, -16);
    send(1'b0, 1'b1, -1, 1);
    for (int k = 3; k < LEN; k++) send(1'b0, 1'b1, rnd_5b(), rnd_5b());
    bp_en = 1'b1;
    send_line(1'b1, 1'b1);
    drain();
    chk(ovf_sticky == 1'b0, "R3", int'(ovf_sticky), 0);

    // R7: azimuth mode closes input after each line until reload
    @(negedge clk);
    mode_az = 1'b1;
    mon_req = "R7";
    bp_en = 1'b1;
    send_line(1'b0, 1'b1);
    drain();
    sample_ready("R7", 1'b0);
    repeat (5) @(negedge clk);
    sample_ready("R7", 1'b0);
    fill_ref_random();
    load_ref(0, LEN - 2);
    sample_ready("R7", 1'b0);
    load_ref(LEN - 1, LEN - 1);
    sample_ready("R7", 1'b1);
    bp_en = 1'b1;
    send_line(1'b0, 1'b1);
    drain();
    sample_ready("R7", 1'b0);

    // R2 / R3: rounding ties, clamp at both ends, sticky flag
    fill_ref_random();
    ref_i[0] = -32768; ref_q[0] = -32768;
    ref_i[1] =  32767; ref_q[1] =  32767;
    ref_i[2] =  16384; ref_q[2] = 0;
    ref_i[3] =  16384; ref_q[3] = 0;
    ref_i[4] =  16383; ref_q[4] = 0;
    ref_i[5] = -32768; ref_q[5] = 0;
    load_ref(0, LEN - 1);
    mon_req = "R2";
    send(1'b1, 1'b0, -32768, -32768);
    send(1'b0, 1'b0, -32768, -32768);
    send(1'b0, 1'b0, 1, 0);
    send(1'b0, 1'b0, -1, 0);
    send(1'b0, 1'b0, 1, 0);
    send(1'b0, 1'b0, -32768, 0);
    drain();
    chk(exp_i[(wp - 6) % QD] == MAXO, "R2", exp_i[(wp - 6) % QD], MAXO);
    chk(exp_i[(wp - 5) % QD] == -MAXO, "R2", exp_i[(wp - 5) % QD], -MAXO);
    chk(ovf_sticky == 1'b1, "R3", int'(ovf_sticky), 1);
    mon_req = "R3";
    for (int k = 6; k < LEN; k++) send(1'b0, 1'b0, rnd_small() / 4, rnd_small() / 4);
    drain();
    chk(ovf_sticky == 1'b1, "R3", int'(ovf_sticky), 1);
    sample_ready("R7", 1'b0);
    chk(rp == wp, "R5", rp, wp);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule